// File: doc/BRIEF.md
# Interrupt Source Sense and Mask Bank

This block takes a bank of asynchronous interrupt request lines and turns each into a pending bit and an enable bit. Each line has three configuration bits of its own: polarity, trigger type (level or edge) and a dual-edge enable. The inputs are resynchronised to the block clock before any sensing. A level-sensed line's pending bit follows its input, with polarity applied. An edge-sensed line latches its pending bit until software clears it.

Software drives a simple single-cycle register bus. Enable bits can only be changed through two write-only registers, one that sets bits and one that clears them, so that no read-modify-write is needed. A third write-only register carries a line number and a set/clear flag. It injects or acknowledges an edge-latched pending bit, and serves for interrupts sent between processors. The pending vector, the enable vector and their AND are brought out for downstream routing.

Top module: `irq_sense_bank`

## Requirements
- R1: After reset, every line reads back as positive polarity (polarity register all ones), level trigger (trigger register zero) and dual-edge off (dual register zero), and the enable vector is zero.
- R2: The read-only configuration word at word address 0 returns NUM_SRC/8 - 1 in bits [5:0] and zero above; the line count is a multiple of 8.
- R3: A level line (trigger bit 0) reports pending equal to its input when its polarity bit is 1 and to the inverted input when it is 0, two clock edges after the input settles; edge-control writes to a level line have no effect.
- R4: An edge line (trigger bit 1, dual bit 0) latches pending on a rising input when its polarity bit is 1 and on a falling input when it is 0; the opposite edge neither sets nor clears it.
- R5: An edge line with its dual bit set latches pending on either input edge, whatever its polarity bit holds; an unchanged input sets nothing.
- R6: A write to the enable-set register (word address 4) sets every enable bit whose data bit is 1; data bits of 0 leave their enables unchanged.
- R7: A write to the enable-clear register (word address 5) clears every enable bit whose data bit is 1; data bits of 0 leave their enables unchanged.
- R8: A write to the edge-control register (word address 6) with bit 31 at 1 sets the pending bit of the edge line numbered in the low log2(NUM_SRC) bits; with bit 31 at 0 it clears it; the effect is visible from the next cycle.
- R9: When an edge is detected on a line in the same cycle that an edge-control clear for that line is written, the pending bit ends up set.
- R10: The active output equals the pending vector ANDed with the enable vector; pending and enable vectors also read back at word addresses 7 and 8, and polarity, trigger and dual registers at 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | NUM_SRC | Asynchronous interrupt request lines |
| busWe | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 4 | Register word address |
| busWdata | input | DATA_W | Register write data |
| busRdata | output | DATA_W | Register read data for busAddr, combinational |
| pendVec | output | NUM_SRC | Pending bit per line |
| maskVec | output | NUM_SRC | Enable bit per line |
| activeVec | output | NUM_SRC | Pending and enabled lines |

## Verification
On every cycle the assertions hold that enable bits rise only after an enable-set write and fall only after an enable-clear write. They also hold that a latched edge pending bit drops only after an edge-control clear, that an edge-control set on an edge line shows up next cycle, and that the configuration word never varies. Which input pattern sets a pending bit under each polarity, trigger and dual-edge combination, that level lines ignore edge-control writes, that zero data bits leave enables alone, and that a detected edge beats a same-cycle clear can only be shown by the bench's scenarios. These scenarios drive timed input changes and compare against expected vectors.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  localparam int REG_ADDR_W    = 4;
  localparam int EDGE_SET_BIT  = 31;
  localparam int CFG_CNT_W     = 6;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CFG  = 4'd0,
    REG_POL  = 4'd1,
    REG_TRIG = 4'd2,
    REG_DUAL = 4'd3,
    REG_MSET = 4'd4,
    REG_MCLR = 4'd5,
    REG_EDGE = 4'd6,
    REG_PEND = 4'd7,
    REG_MASK = 4'd8
  } regAddrE;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic edgeWr;
    logic edgeSet;
  } senseStrobeT;

endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [NUM_SRC-1:0]    pendVec,
  input  logic [NUM_SRC-1:0]    maskVec,
  output senseStrobeT           strobe,
  output logic [NUM_SRC-1:0]    polReg,
  output logic [NUM_SRC-1:0]    trigReg,
  output logic [NUM_SRC-1:0]    dualReg,
  output logic [DATA_W-1:0]     busRdata
);

  localparam logic [CFG_CNT_W-1:0] CNT_FIELD = CFG_CNT_W'(NUM_SRC / 8 - 1);

  logic [NUM_SRC-1:0] wrBits;
  assign wrBits = busWdata[NUM_SRC-1:0];

  // configuration registers: positive polarity, level trigger at reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polReg  <= '1;
      trigReg <= '0;
      dualReg <= '0;
    end else if (busWe) begin
      if (busAddr == REG_POL)  polReg  <= wrBits;
      if (busAddr == REG_TRIG) trigReg <= wrBits;
      if (busAddr == REG_DUAL) dualReg <= wrBits;
    end
  end

  // strobes towards the datapath
  always_comb begin
    strobe.maskSet = busWe && (busAddr == REG_MSET);
    strobe.maskClr = busWe && (busAddr == REG_MCLR);
    strobe.edgeWr  = busWe && (busAddr == REG_EDGE);
    strobe.edgeSet = busWdata[EDGE_SET_BIT];
  end

  // read mux
  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_CFG:  busRdata[CFG_CNT_W-1:0] = CNT_FIELD;
      REG_POL:  busRdata[NUM_SRC-1:0]   = polReg;
      REG_TRIG: busRdata[NUM_SRC-1:0]   = trigReg;
      REG_DUAL: busRdata[NUM_SRC-1:0]   = dualReg;
      REG_PEND: busRdata[NUM_SRC-1:0]   = pendVec;
      REG_MASK: busRdata[NUM_SRC-1:0]   = maskVec;
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_sense_dp.sv
module irq_sense_dp
  import irq_sense_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] polReg,
  input  logic [NUM_SRC-1:0] trigReg,
  input  logic [NUM_SRC-1:0] dualReg,
  input  senseStrobeT        strobe,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [IDX_W-1:0]   edgeIdx,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] activeVec
);

  logic [NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] edgePend;

  irq_sense_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (srcIn),
    .syncOut (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  // enable bits: changed only by set and clear strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskVec <= '0;
    end else begin
      maskVec <= (maskVec | (strobe.maskSet ? wrBits : '0))
                 & ~(strobe.maskClr ? wrBits : '0);
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic lvlNow;
    logic lvlPrev;
    logic hitEdge;
    logic swSet;
    logic swClr;

    assign lvlNow  = syncQ[i] ~^ polReg[i];
    assign lvlPrev = prevQ[i] ~^ polReg[i];
    assign hitEdge = dualReg[i] ? (syncQ[i] ^ prevQ[i]) : (lvlNow & ~lvlPrev);
    assign swSet   = strobe.edgeWr && strobe.edgeSet  && (edgeIdx == IDX_W'(i));
    assign swClr   = strobe.edgeWr && !strobe.edgeSet && (edgeIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 edgePend[i] <= 1'b0;
      else if (!trigReg[i])      edgePend[i] <= 1'b0;
      else if (hitEdge || swSet) edgePend[i] <= 1'b1;
      else if (swClr)            edgePend[i] <= 1'b0;
    end

    assign pendVec[i] = trigReg[i] ? edgePend[i] : lvlNow;
  end

  assign activeVec = pendVec & maskVec;

endmodule

// File: rtl/irq_sense_bank.sv
module irq_sense_bank
  import irq_sense_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcIn,
  input  logic                  busWe,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic [NUM_SRC-1:0]    pendVec,
  output logic [NUM_SRC-1:0]    maskVec,
  output logic [NUM_SRC-1:0]    activeVec
);

  localparam int IDX_W = $clog2(NUM_SRC);

  senseStrobeT        strobe;
  logic [NUM_SRC-1:0] polReg;
  logic [NUM_SRC-1:0] trigReg;
  logic [NUM_SRC-1:0] dualReg;

  irq_sense_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .pendVec  (pendVec),
    .maskVec  (maskVec),
    .strobe   (strobe),
    .polReg   (polReg),
    .trigReg  (trigReg),
    .dualReg  (dualReg),
    .busRdata (busRdata)
  );

  irq_sense_dp #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .polReg    (polReg),
    .trigReg   (trigReg),
    .dualReg   (dualReg),
    .strobe    (strobe),
    .wrBits    (busWdata[NUM_SRC-1:0]),
    .edgeIdx   (busWdata[IDX_W-1:0]),
    .pendVec   (pendVec),
    .maskVec   (maskVec),
    .activeVec (activeVec)
  );

endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk
  import irq_sense_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWe,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic                  edgeFlag,
  input logic [IDX_W-1:0]      edgeIdx,
  input logic [DATA_W-1:0]     busRdata,
  input logic [NUM_SRC-1:0]    pendVec,
  input logic [NUM_SRC-1:0]    maskVec,
  input logic [NUM_SRC-1:0]    trigVec
);

  // R2
  cfg_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == REG_CFG) |-> (busRdata == DATA_W'(NUM_SRC / 8 - 1)));

  // R6
  mask_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(maskVec & ~$past(maskVec))) |-> ($past(busWe) && $past(busAddr) == REG_MSET));

  // R7
  mask_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(~maskVec & $past(maskVec))) |-> ($past(busWe) && $past(busAddr) == REG_MCLR));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(pendVec) & ~pendVec & $past(trigVec) & trigVec))
      |-> ($past(busWe) && $past(busAddr) == REG_EDGE && !$past(edgeFlag)));

  // R8
  edge_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_EDGE && edgeFlag && trigVec[edgeIdx])
      |=> pendVec[$past(edgeIdx)]);

endmodule

bind irq_sense_bank irq_sense_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .edgeFlag (busWdata[irq_sense_pkg::EDGE_SET_BIT]),
  .edgeIdx  (busWdata[IDX_W-1:0]),
  .busRdata (busRdata),
  .pendVec  (pendVec),
  .maskVec  (maskVec),
  .trigVec  (trigReg)
);

// File: tb/test_irq_sense_bank.sv
module test_irq_sense_bank;

  localparam int NUM_SRC = 32;
  localparam int DATA_W  = 32;
  localparam logic [3:0] A_CFG = 4'd0, A_POL = 4'd1, A_TRIG = 4'd2, A_DUAL = 4'd3,
                         A_MSET = 4'd4, A_MCLR = 4'd5, A_EDGE = 4'd6,
                         A_PEND = 4'd7, A_MASK = 4'd8;
  localparam int TSRC = 5;
  localparam int NVEC = 11;
  // fields: [0] pol, [1] trig, [2] dual, [3] input before, [4] input after, [5] expected pending
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110001, 6'b001001, 6'b101000, 6'b010000,
    6'b110011, 6'b001011, 6'b101010, 6'b010010,
    6'b101111, 6'b110110, 6'b011111
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_SRC-1:0] srcIn = '0;
  logic              busWe = 1'b0;
  logic [3:0]        busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [NUM_SRC-1:0] pendVec, maskVec, activeVec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_sense_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_irq_sense_bank (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pendVec(pendVec),
    .maskVec(maskVec), .activeVec(activeVec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busAddr = A_CFG; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
    busAddr = A_CFG;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_POL, d);  chk("R1 polarity", d, 32'hFFFF_FFFF);
    rd(A_TRIG, d); chk("R1 trigger", d, 32'h0);
    rd(A_DUAL, d); chk("R1 dual", d, 32'h0);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0);
    chk("R1 maskVec", maskVec, 32'h0);
    chk("R1 pendVec", pendVec, 32'h0);

    // R2 configuration word
    rd(A_CFG, d); chk("R2 count field", d, 32'd3);

    // R6 / R7 enable set and clear
    wr(A_MSET, 32'h0000_0011); rd(A_MASK, d); chk("R6 set", d, 32'h11);
    wr(A_MSET, 32'h0);         rd(A_MASK, d); chk("R6 zero write", d, 32'h11);
    wr(A_MSET, 32'h0000_0100); rd(A_MASK, d); chk("R6 add bit", d, 32'h111);
    wr(A_MCLR, 32'h0);         rd(A_MASK, d); chk("R7 zero write", d, 32'h111);
    wr(A_MCLR, 32'h0000_0010); rd(A_MASK, d); chk("R7 clear", d, 32'h101);
    chk("R7 maskVec", maskVec, 32'h101);

    // R10 active = pending & enable, level lines 0 and 4 high
    @(negedge clk); srcIn[0] = 1'b1; srcIn[4] = 1'b1;
    idle(4);
    rd(A_PEND, d); chk("R10 pending read", d, 32'h11);
    chk("R10 activeVec", activeVec, 32'h1);

    // R3 edge-control writes ignored by level lines
    wr(A_EDGE, 32'h8000_0002); idle(1); chk("R3 set on level ignored", pendVec, 32'h11);
    wr(A_EDGE, 32'h0000_0000); idle(1); chk("R3 clear on level ignored", pendVec, 32'h11);
    @(negedge clk); srcIn = '0;
    idle(4);

    // R3 R4 R5 table of sense modes on one line
    for (int k = 0; k < NVEC; k++) begin
      logic [5:0] v;
      string tag;
      v = VEC[k];
      tag = !v[1] ? "R3 level" : (v[2] ? "R5 dual edge" : "R4 single edge");
      wr(A_POL, ~(32'(!v[0]) << TSRC));
      wr(A_TRIG, 32'(v[1]) << TSRC);
      wr(A_DUAL, 32'(v[2]) << TSRC);
      @(negedge clk); srcIn[TSRC] = v[3];
      idle(5);
      wr(A_EDGE, 32'(TSRC));
      @(negedge clk); srcIn[TSRC] = v[4];
      idle(5);
      rd(A_PEND, d);
      chk($sformatf("%s vector %0d", tag, k), d, 32'(v[5]) << TSRC);
    end

    // restore and set lines 7 and 9 to rising edge
    wr(A_POL, 32'hFFFF_FFFF);
    wr(A_DUAL, 32'h0);
    @(negedge clk); srcIn = '0;
    idle(4);
    wr(A_TRIG, 32'h0000_0280);
    idle(1);
    chk("R4 clean start", pendVec, 32'h0);

    // R8 software inject and acknowledge
    wr(A_EDGE, 32'h8000_0009); chk("R8 inject", pendVec, 32'h200);
    rd(A_PEND, d);             chk("R8 inject read", d, 32'h200);
    wr(A_EDGE, 32'h0000_0009); chk("R8 acknowledge", pendVec, 32'h0);

    // R4 latched through the falling input
    @(negedge clk); srcIn[9] = 1'b1;
    idle(4);
    chk("R4 rise latched", pendVec, 32'h200);
    @(negedge clk); srcIn[9] = 1'b0;
    idle(4);
    chk("R4 held after fall", pendVec, 32'h200);
    wr(A_EDGE, 32'h0000_0009);

    // R9 edge and clear in the same cycle
    @(negedge clk); srcIn[7] = 1'b1;
    @(negedge clk);
    wr(A_EDGE, 32'h0000_0007);
    chk("R9 edge beats clear", pendVec, 32'h080);
    wr(A_EDGE, 32'h0000_0007);
    chk("R8 clear without edge", pendVec, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule